// File: doc/BRIEF.md
# PCM Voice Serial Port

This block carries 8-bit companded voice samples between a parallel codec core and a time-division-multiplexed serial bus. The bus side has one shared bit clock, separate transmit and receive frame-sync inputs, a serial receive input, a serial transmit output with its own output-enable (the pad turns this pair into a three-state driver), and a low-active strobe that marks the transmit time slot. The logic runs on a single system clock at least four times the bit clock. It passes the bit clock, both syncs and the receive input through synchronizers and acts on the edges it detects.

The block works out the framing style from the length of each transmit sync pulse. A pulse of one or two bit periods selects short-frame rules and a pulse of three or more selects long-frame rules. The new style applies from the next frame on, and both directions use it. In each transmit slot the block sends the byte the core handed over during the previous frame. At the end of each receive slot it hands one byte back to the core. After power-down is released, the output stays off until the second transmit sync.

On the core side the transmit byte enters through a valid/ready pair. Ready is high whenever the block is powered up, and an accepted byte replaces any byte still waiting. The receive byte leaves through a valid/ready pair. Valid stays up with the byte until ready is seen. The serial bus cannot be stalled, so a byte that is still unread when the next one completes is overwritten.

Top module: `pcm_tdm_port`

## Requirements
- R1: After reset the output-enable is low, the slot strobe is high, receive valid is low, and the short-frame rules are in force.
- R2: Under short-frame rules, a transmit sync that is high at a bit-clock falling edge causes the next rising edge to enable the output and drive bit 7, the sign bit. Bits 6 down to 0 follow on the next seven rising edges, and the falling edge after the eighth rising edge disables the output.
- R3: Under short-frame rules, a receive sync that is high at a bit-clock falling edge causes the next eight falling edges to capture the receive input, most significant bit first.
- R4: A transmit sync pulse that spans three or more bit-clock falling edges selects long-frame rules for the following frames. A pulse that spans one or two selects short-frame rules. The receive sync has no say in this choice.
- R5: Under long-frame rules, the output is enabled and drives bit 7 at the later of the transmit sync rising and the bit clock rising, and the next seven bit-clock rising edges shift out bits 6 down to 0. The output is disabled at the later of two events: the falling edge after the eighth rising edge, or the transmit sync going low.
- R6: Under long-frame rules, a receive sync rising edge causes the next eight bit-clock falling edges to capture the receive input, most significant bit first.
- R7: A byte accepted on the transmit valid/ready pair is the byte sent at the next transmit sync. If no byte was accepted, the last one is sent again. Transmit ready is low during power-down, and no byte is taken then.
- R8: The slot strobe is low exactly while the output-enable is high.
- R9: While power-down is high the output-enable is low and the short-frame rules return. After release, the first transmit sync is not answered, and output resumes at the second transmit sync.
- R10: Receive valid rises with a completed byte and, together with the receive data, holds until it is seen with receive ready. It then drops on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwrdn | input | 1 | Power-down; high stops both directions |
| bclk_in | input | 1 | Shared bit clock, asynchronous to clk |
| fsx_in | input | 1 | Transmit frame sync |
| fsr_in | input | 1 | Receive frame sync |
| dr_in | input | 1 | Serial receive data |
| dx | output | 1 | Serial transmit data |
| dx_oe | output | 1 | Output-enable for the transmit pad |
| slot_n | output | 1 | Transmit time-slot strobe, low-active |
| tx_data | input | SAMPLE_W | Byte to send in the next frame |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Byte is accepted when high with tx_valid |
| rx_data | output | SAMPLE_W | Last received byte |
| rx_valid | output | 1 | rx_data holds an unread byte |
| rx_ready | input | 1 | Core takes rx_data |

## Verification
The bench first sends a sync right after reset and checks that it goes unanswered. A design that counted syncs from the wrong point would drive the bus one frame early. It then sends a three-bit-period sync while the short-frame rules are still in force, which catches a design that applies a new framing style to the frame that selected it. A sync held past the eighth bit must keep the output enabled until the sync falls. A two-period sync must bring back short-frame timing, so a design that sends in the wrong bit period or drops the output one bit early fails there. Further checks confirm that power-down resets the framing style and the sync count and refuses core bytes, and that an unread received byte stays valid until the core takes it.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

  typedef enum logic {
    FRM_SHORT = 1'b0,
    FRM_LONG  = 1'b1
  } frame_mode_e;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_ARM  = 2'd1,
    TX_SEND = 2'd2,
    TX_TAIL = 2'd3
  } tx_state_e;

endpackage

// File: rtl/pcm_in_sync.sv
module pcm_in_sync #(
  parameter int W      = 4,
  parameter int EDGE_N = 3,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      async_in,
  output logic [W-1:0]      lvl,
  output logic [EDGE_N-1:0] rise,
  output logic [EDGE_N-1:0] fall
);

  logic [W-1:0]      stg [STAGES];
  logic [EDGE_N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      prev_q <= '0;
    end else begin
      stg[0] <= async_in;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prev_q <= stg[STAGES-1][EDGE_N-1:0];
    end
  end

  assign lvl  = stg[STAGES-1];
  assign rise = lvl[EDGE_N-1:0] & ~prev_q;
  assign fall = ~lvl[EDGE_N-1:0] & prev_q;

endmodule

// File: rtl/pcm_frame_detect.sv
module pcm_frame_detect
  import pcm_port_pkg::*;
#(
  parameter int LONG_MIN = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pwrdn,
  input  logic        fsx_lvl,
  input  logic        fsx_rise,
  input  logic        fsx_fall,
  input  logic        bclk_fall,
  output frame_mode_e mode,
  output logic        tx_allow
);

  localparam int LW = $clog2(LONG_MIN + 1);
  localparam logic [LW-1:0] LEN_SAT = LW'(LONG_MIN);

  logic [LW-1:0] plen;
  logic [1:0]    seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plen <= '0;
      seen <= '0;
      mode <= FRM_SHORT;
    end else if (pwrdn) begin
      plen <= '0;
      seen <= '0;
      mode <= FRM_SHORT;
    end else begin
      // pulse length in bit periods, saturating
      if (fsx_fall) begin
        mode <= (plen >= LEN_SAT) ? FRM_LONG : FRM_SHORT;
        plen <= '0;
      end else if (fsx_lvl && bclk_fall && plen != LEN_SAT) begin
        plen <= plen + LW'(1);
      end
      // syncs seen since power-up
      if (fsx_rise && seen != 2'd2) seen <= seen + 2'd1;
    end
  end

  assign tx_allow = !pwrdn && ((seen == 2'd2) || (fsx_rise && seen == 2'd1));

endmodule

// File: rtl/pcm_tx_slot.sv
module pcm_tx_slot
  import pcm_port_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pwrdn,
  input  frame_mode_e         mode,
  input  logic                allow,
  input  logic                bclk_lvl,
  input  logic                bclk_rise,
  input  logic                bclk_fall,
  input  logic                fsx_lvl,
  input  logic [SAMPLE_W-1:0] tx_data,
  input  logic                tx_valid,
  output logic                tx_ready,
  output logic                dx,
  output logic                dx_oe,
  output logic                slot_n
);

  localparam int CW = $clog2(SAMPLE_W + 1);
  localparam logic [CW-1:0] FULL = CW'(SAMPLE_W);

  tx_state_e             state;
  frame_mode_e           slot_mode;
  logic [SAMPLE_W-1:0]   hold_q;
  logic [SAMPLE_W-1:0]   shreg;
  logic [CW-1:0]         sent;
  logic                  used;
  logic                  idle_sync;
  logic                  claim;
  logic                  go_long;
  logic                  arm_short;
  logic                  go_short;

  assign idle_sync = (state == TX_IDLE) && fsx_lvl && !used;
  assign claim     = idle_sync && ((mode == FRM_LONG) ? bclk_lvl : bclk_fall);
  assign go_long   = claim && (mode == FRM_LONG) && allow;
  assign arm_short = claim && (mode == FRM_SHORT) && allow;
  assign go_short  = (state == TX_ARM) && bclk_rise;
  assign tx_ready  = !pwrdn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else if (tx_valid && tx_ready) hold_q <= tx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= TX_IDLE;
      slot_mode <= FRM_SHORT;
      shreg     <= '0;
      sent      <= '0;
      used      <= 1'b0;
      dx        <= 1'b0;
    end else if (pwrdn) begin
      state <= TX_IDLE;
      sent  <= '0;
      used  <= 1'b0;
    end else begin
      if (!fsx_lvl) used <= 1'b0;
      else if (claim) used <= 1'b1;

      if (go_long || go_short) begin
        dx        <= hold_q[SAMPLE_W-1];
        shreg     <= {hold_q[SAMPLE_W-2:0], 1'b0};
        sent      <= CW'(1);
        state     <= TX_SEND;
        if (go_long) slot_mode <= FRM_LONG;
      end else begin
        unique case (state)
          TX_IDLE: begin
            if (arm_short) begin
              state     <= TX_ARM;
              slot_mode <= FRM_SHORT;
            end
          end
          TX_ARM: ;
          TX_SEND: begin
            if (bclk_rise && sent != FULL) begin
              dx    <= shreg[SAMPLE_W-1];
              shreg <= shreg << 1;
              sent  <= sent + CW'(1);
            end else if (bclk_fall && sent == FULL) begin
              state <= (slot_mode == FRM_SHORT || !fsx_lvl) ? TX_IDLE : TX_TAIL;
            end
          end
          TX_TAIL: begin
            if (!fsx_lvl) state <= TX_IDLE;
          end
          default: state <= TX_IDLE;
        endcase
      end
    end
  end

  assign dx_oe  = (state == TX_SEND) || (state == TX_TAIL);
  assign slot_n = !dx_oe;

endmodule

// File: rtl/pcm_rx_slot.sv
module pcm_rx_slot
  import pcm_port_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pwrdn,
  input  frame_mode_e         mode,
  input  logic                bclk_fall,
  input  logic                fsr_lvl,
  input  logic                fsr_rise,
  input  logic                fsr_fall,
  input  logic                dr_lvl,
  input  logic                rx_ready,
  output logic [SAMPLE_W-1:0] rx_data,
  output logic                rx_valid
);

  localparam int CW = $clog2(SAMPLE_W);
  localparam logic [CW-1:0] LAST = CW'(SAMPLE_W - 1);

  logic                active;
  logic                rused;
  logic [CW-1:0]       cnt;
  logic [SAMPLE_W-1:0] shreg;
  logic [SAMPLE_W-1:0] next_word;
  logic                arm;

  assign arm = !active && !rused &&
               ((mode == FRM_SHORT) ? (bclk_fall && fsr_lvl) : fsr_rise);
  assign next_word = {shreg[SAMPLE_W-2:0], dr_lvl};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      rused    <= 1'b0;
      cnt      <= '0;
      shreg    <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else if (pwrdn) begin
      active   <= 1'b0;
      rused    <= 1'b0;
      cnt      <= '0;
      rx_valid <= 1'b0;
    end else begin
      if (fsr_fall) rused <= 1'b0;
      else if (arm) rused <= 1'b1;

      if (rx_valid && rx_ready) rx_valid <= 1'b0;

      if (arm) begin
        active <= 1'b1;
        cnt    <= '0;
      end else if (active && bclk_fall) begin
        shreg <= next_word;
        cnt   <= cnt + CW'(1);
        if (cnt == LAST) begin
          active   <= 1'b0;
          rx_data  <= next_word;
          rx_valid <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pcm_tdm_port.sv
module pcm_tdm_port
  import pcm_port_pkg::*;
#(
  parameter int SAMPLE_W    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int LONG_MIN    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pwrdn,
  input  logic                bclk_in,
  input  logic                fsx_in,
  input  logic                fsr_in,
  input  logic                dr_in,
  output logic                dx,
  output logic                dx_oe,
  output logic                slot_n,
  input  logic [SAMPLE_W-1:0] tx_data,
  input  logic                tx_valid,
  output logic                tx_ready,
  output logic [SAMPLE_W-1:0] rx_data,
  output logic                rx_valid,
  input  logic                rx_ready
);

  // synchronizer lane positions; edges are kept for the lower lanes only
  localparam int L_BCLK = 0;
  localparam int L_FSX  = 1;
  localparam int L_FSR  = 2;
  localparam int L_DR   = 3;
  localparam int N_LANE = 4;
  localparam int N_EDGE = 3;

  logic [N_LANE-1:0] raw_in;
  logic [N_LANE-1:0] lvl;
  logic [N_EDGE-1:0] rise;
  logic [N_EDGE-1:0] fall;
  frame_mode_e       mode;
  logic              tx_allow;

  assign raw_in = {dr_in, fsr_in, fsx_in, bclk_in};

  pcm_in_sync #(
    .W      (N_LANE),
    .EDGE_N (N_EDGE),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (raw_in),
    .lvl      (lvl),
    .rise     (rise),
    .fall     (fall)
  );

  pcm_frame_detect #(
    .LONG_MIN (LONG_MIN)
  ) u_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwrdn     (pwrdn),
    .fsx_lvl   (lvl[L_FSX]),
    .fsx_rise  (rise[L_FSX]),
    .fsx_fall  (fall[L_FSX]),
    .bclk_fall (fall[L_BCLK]),
    .mode      (mode),
    .tx_allow  (tx_allow)
  );

  pcm_tx_slot #(
    .SAMPLE_W (SAMPLE_W)
  ) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwrdn     (pwrdn),
    .mode      (mode),
    .allow     (tx_allow),
    .bclk_lvl  (lvl[L_BCLK]),
    .bclk_rise (rise[L_BCLK]),
    .bclk_fall (fall[L_BCLK]),
    .fsx_lvl   (lvl[L_FSX]),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .dx        (dx),
    .dx_oe     (dx_oe),
    .slot_n    (slot_n)
  );

  pcm_rx_slot #(
    .SAMPLE_W (SAMPLE_W)
  ) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwrdn     (pwrdn),
    .mode      (mode),
    .bclk_fall (fall[L_BCLK]),
    .fsr_lvl   (lvl[L_FSR]),
    .fsr_rise  (rise[L_FSR]),
    .fsr_fall  (fall[L_FSR]),
    .dr_lvl    (lvl[L_DR]),
    .rx_ready  (rx_ready),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid)
  );

endmodule

// File: rtl/pcm_tdm_port_chk.sv
module pcm_tdm_port_chk #(
  parameter int SAMPLE_W    = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                pwrdn,
  input logic                fsx_in,
  input logic                dx_oe,
  input logic [SAMPLE_W-1:0] rx_data,
  input logic                rx_valid,
  input logic                rx_ready
);

  // checker-side view of the transmit sync, delayed like the port sees it
  logic [SYNC_STAGES-1:0] fsx_d;
  logic                   fsx_seen_q;
  logic [1:0]             sync_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsx_d      <= '0;
      fsx_seen_q <= 1'b0;
      sync_cnt   <= '0;
    end else begin
      fsx_d      <= {fsx_d[SYNC_STAGES-2:0], fsx_in};
      fsx_seen_q <= fsx_d[SYNC_STAGES-1];
      if (pwrdn) sync_cnt <= '0;
      else if (fsx_d[SYNC_STAGES-1] && !fsx_seen_q && sync_cnt != 2'd2)
        sync_cnt <= sync_cnt + 2'd1;
    end
  end

  // R9
  power_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwrdn |=> !dx_oe);

  // R9
  second_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dx_oe |-> sync_cnt == 2'd2);

  // R10
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !pwrdn) |=> rx_valid);

  // R10
  rx_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> (!rx_valid || !$stable(rx_data)));

endmodule

bind pcm_tdm_port pcm_tdm_port_chk #(
  .SAMPLE_W    (SAMPLE_W),
  .SYNC_STAGES (SYNC_STAGES)
) u_chk (.*);

// File: tb/pcm_tdm_port_bench.sv
module pcm_tdm_port_bench;

  localparam int NPER = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwrdn = 1'b0;
  logic       bclk_in = 1'b0;
  logic       fsx_in = 1'b0;
  logic       fsr_in = 1'b0;
  logic       dr_in = 1'b0;
  logic       dx, dx_oe, slot_n;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_ready = 1'b1;

  int n_chk = 0;
  int n_fail = 0;
  int got_n = 0;
  logic [7:0] got_byte = 8'h00;

  logic smp_oe [16];
  logic smp_dx [16];
  logic smp_sn [16];

  always #2 clk = ~clk;

  pcm_tdm_port u_pcm_tdm_port (
    .clk(clk), .rst_n(rst_n), .pwrdn(pwrdn), .bclk_in(bclk_in),
    .fsx_in(fsx_in), .fsr_in(fsr_in), .dr_in(dr_in), .dx(dx),
    .dx_oe(dx_oe), .slot_n(slot_n), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready)
  );

  always @(posedge clk)
    if (rst_n && rx_valid && rx_ready) begin
      got_byte <= rx_data;
      got_n    <= got_n + 1;
    end

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk) tx_data = b; tx_valid = 1'b1;
    @(negedge clk) tx_valid = 1'b0;
  endtask

  // one bit period = 8 system clocks; outputs sampled just before the fall
  task automatic run_frame(input int fx_len, input int fr_len,
                           input logic [7:0] rbyte, input bit rlong);
    for (int k = 0; k < NPER; k++) begin
      @(negedge clk);
      bclk_in = 1'b1;
      fsx_in  = (k < fx_len);
      fsr_in  = (k < fr_len);
      if (rlong) dr_in = (k < 8) ? rbyte[7-k] : 1'b0;
      else       dr_in = (k >= 1 && k <= 8) ? rbyte[8-k] : 1'b0;
      repeat (3) @(negedge clk);
      smp_oe[k] = dx_oe;
      smp_dx[k] = dx;
      smp_sn[k] = slot_n;
      @(negedge clk) bclk_in = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic check_tx(input int start, input int endp, input logic [7:0] b,
                          input string req);
    logic [15:0] exp_oe = '0;
    logic [15:0] got_oe = '0;
    logic [15:0] got_sn = '0;
    logic [7:0]  got_b = '0;
    for (int k = 0; k < NPER; k++) begin
      exp_oe[k] = (start >= 0) && (k >= start) && (k <= endp);
      got_oe[k] = smp_oe[k];
      got_sn[k] = smp_sn[k];
    end
    chk(got_oe == exp_oe, {req, " enable window"}, got_oe, exp_oe);
    // R8: strobe low exactly in the slot
    chk(got_sn[NPER-1:0] == ~got_oe[NPER-1:0], "R8 strobe", got_sn, ~got_oe);
    if (start >= 0) begin
      for (int i = 0; i < 8; i++) got_b[7-i] = smp_dx[start+i];
      chk(got_b == b, {req, " data msb first"}, {8'h0, got_b}, {8'h0, b});
    end
  endtask

  task automatic check_rx(input logic [7:0] b, input int n_before, input string req);
    chk(got_n == n_before + 1, {req, " byte count"}, 16'(got_n), 16'(n_before + 1));
    chk(got_byte == b, {req, " byte value"}, {8'h0, got_byte}, {8'h0, b});
  endtask

  task automatic t_reset();
    chk(dx_oe == 1'b0, "R1 enable", {15'h0, dx_oe}, 16'h0);
    chk(slot_n == 1'b1, "R1 strobe", {15'h0, slot_n}, 16'h1);
    chk(rx_valid == 1'b0, "R1 rx valid", {15'h0, rx_valid}, 16'h0);
  endtask

  task automatic t_first_sync();
    send_byte(8'hA5);
    run_frame(1, 0, 8'h00, 0);
    check_tx(-1, -1, 8'h00, "R9 first sync silent");
  endtask

  task automatic t_short();
    int n0;
    run_frame(1, 0, 8'h00, 0);
    check_tx(1, 8, 8'hA5, "R2 R7 repeat");
    send_byte(8'h3C);
    n0 = got_n;
    run_frame(1, 1, 8'h96, 0);
    check_tx(1, 8, 8'h3C, "R2 R7 new byte");
    check_rx(8'h96, n0, "R3");
  endtask

  task automatic t_to_long();
    int n0;
    run_frame(3, 0, 8'h00, 0);
    check_tx(1, 8, 8'h3C, "R4 old rules this frame");
    n0 = got_n;
    run_frame(3, 3, 8'h5A, 1);
    check_tx(0, 7, 8'h3C, "R4 R5 long");
    check_rx(8'h5A, n0, "R6");
  endtask

  task automatic t_long_hold();
    run_frame(10, 0, 8'h00, 0);
    check_tx(0, 9, 8'h3C, "R5 sync outlasts bits");
  endtask

  task automatic t_back_short();
    send_byte(8'hC3);
    run_frame(2, 0, 8'h00, 0);
    check_tx(0, 7, 8'hC3, "R4 still long");
    run_frame(1, 0, 8'h00, 0);
    check_tx(1, 8, 8'hC3, "R4 back to short");
  endtask

  task automatic t_rx_hold();
    rx_ready = 1'b0;
    run_frame(1, 1, 8'hE1, 0);
    chk(rx_valid == 1'b1, "R10 valid held", {15'h0, rx_valid}, 16'h1);
    chk(rx_data == 8'hE1, "R10 data held", {8'h0, rx_data}, 16'h00E1);
    repeat (5) @(negedge clk);
    chk(rx_valid == 1'b1, "R10 still held", {15'h0, rx_valid}, 16'h1);
    rx_ready = 1'b1;
    @(negedge clk);
    chk(rx_valid == 1'b0, "R10 drop after take", {15'h0, rx_valid}, 16'h0);
    chk(got_byte == 8'hE1, "R10 taken byte", {8'h0, got_byte}, 16'h00E1);
  endtask

  task automatic t_pwrdn();
    run_frame(3, 0, 8'h00, 0);               // selects long rules
    @(negedge clk) pwrdn = 1'b1;
    @(negedge clk);
    chk(tx_ready == 1'b0, "R7 ready low in power-down", {15'h0, tx_ready}, 16'h0);
    send_byte(8'h77);                        // must be refused
    run_frame(1, 0, 8'h00, 0);
    check_tx(-1, -1, 8'h00, "R9 power-down quiet");
    @(negedge clk) pwrdn = 1'b0;
    run_frame(1, 0, 8'h00, 0);
    check_tx(-1, -1, 8'h00, "R9 first sync after release");
    run_frame(1, 0, 8'h00, 0);
    check_tx(1, 8, 8'hC3, "R9 R7 second sync short rules");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_sync();
    t_short();
    t_to_long();
    t_long_hold();
    t_back_short();
    t_rx_hold();
    t_pwrdn();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule